// File: doc/BRIEF.md
# 2D Strided Transfer Address Generator

This block turns a four-word transfer command into a series of per-line memory requests. Together the requests cover a rectangle cut out of a frame that is stored line after line in memory. Software or a host engine writes the command one 32-bit word at a time, each word tagged with its index. The command carries:

- the bytes moved per line;
- the direction and the byte start address of the first line;
- the number of lines, minus one;
- the stride, which is the byte distance between the starts of consecutive lines (the stored frame's line pitch).

Once the last word is accepted, the generator issues one request per line over a ready/valid handshake. Each request carries the line's start address, its byte count and the direction, and the final line is flagged. A one-cycle completion pulse follows the acceptance of the final line, and the block is then ready for the next command. Moving data, the memory bus protocol and clock crossing are left to the blocks around it.

Top module: `stride_addr_gen`

## Requirements
- R1: The per-line byte count `req_len` is taken from bits [14:0] of command word 0 (`cmd_idx` = 0). Bits [31:15] of that word have no effect.
- R2: `req_write` equals bit 31 of command word 1 (`cmd_idx` = 1): 1 means write and 0 means read. It is the same on every line of a transfer.
- R3: The first request's `req_addr` equals bits [30:0] of command word 1.
- R4: A transfer issues exactly N+1 requests, where N is bits [23:0] of command word 2 (`cmd_idx` = 2). Bits [31:24] of that word have no effect. `req_last` is 1 on the final request only.
- R5: Request n (counted from 0) has `req_addr` = start + n × stride, modulo 2^31. The stride is bits [23:0] of command word 3 (`cmd_idx` = 3), and bits [31:24] of that word have no effect.
- R6: Command words are accepted only in the order 0, 1, 2, 3. A write whose index is not the expected one is ignored. It pulses `cmd_err` in the cycle after the write, and the expected index stays the same. The transfer starts only after word 3 is accepted.
- R7: A command write while `busy` is 1 is ignored and pulses `cmd_err` in the next cycle. The running transfer is unaffected.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr`, `req_len`, `req_write` and `req_last` hold their values.
- R9: `done` is 1 for exactly one cycle, in the cycle after the final request's handshake. `busy` is then 0 and a new command can be accepted.
- R10: If the per-line byte count is 0, no request is issued. `done` pulses two cycles after the clock edge that accepts word 3.
- R11: While reset is applied, and right after it, `req_valid`, `req_last`, `done`, `busy` and `cmd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_we | input | 1 | Command word write strobe |
| cmd_idx | input | 2 | Index of the command word being written (0 to 3) |
| cmd_data | input | 32 | Command word value |
| cmd_err | output | 1 | One-cycle pulse: the previous write was refused |
| busy | output | 1 | Transfer being launched or in progress |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | Consumer accepts the presented request |
| req_addr | output | 31 | Byte start address of the line |
| req_len | output | 15 | Bytes on the line |
| req_write | output | 1 | 1 write, 0 read |
| req_last | output | 1 | Marks the final line of the transfer |
| done | output | 1 | One-cycle pulse after the final line is accepted |

## Verification
Some rules are checked by properties on every cycle:

- requests stay stable under backpressure;
- a handshake on a non-final line moves the next address on by exactly the stride;
- the final handshake is followed by a single-cycle `done`;
- writes made while busy raise `cmd_err`;
- a request never carries a zero length.

Other behaviour can only be shown by the bench's scenarios, because it needs an independent model of the command:

- the field extraction with junk in the unused bits;
- the exact line count;
- addresses that wrap past the top of the 31-bit space;
- out-of-order command sequences;
- the empty transfer.

// File: rtl/sag_pkg.sv
// Shared widths and the decoded command record of the strided address generator.
// Assumes a 32-bit command word; the field widths below must fit inside it.
package sag_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 31;
    localparam int LEN_W    = 15;
    localparam int CNT_W    = 24;
    localparam int STRIDE_W = 24;
    localparam int IDX_W    = 2;
    localparam int NUM_WORDS = 4;

    typedef struct packed {
        logic                is_write;
        logic [ADDR_W-1:0]   base;
        logic [LEN_W-1:0]    line_bytes;
        logic [CNT_W-1:0]    lines_m1;
        logic [STRIDE_W-1:0] pitch;
    } xfer_cmd_t;
endpackage

// File: rtl/cmd_loader.sv
// Collects the four command words in strict order and holds the decoded record.
// Assumes the record is only read by the walker while busy is high, so refusing
// writes during busy keeps it stable for the whole transfer.
module cmd_loader
    import sag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output xfer_cmd_t         cmd,
    output logic              launch,
    output logic              err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    logic [IDX_W-1:0] expect_idx;
    logic             accept;

    // A write is taken only when idle and carrying the expected index.
    always_comb accept = we && !busy && (idx == expect_idx);

    // Sequence tracking, refusal pulse and launch pulse after the final word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_idx <= '0;
            launch     <= 1'b0;
            err        <= 1'b0;
        end else begin
            launch <= accept && (expect_idx == LAST_IDX);
            err    <= we && !accept;
            if (accept) expect_idx <= expect_idx + 1'b1;
        end
    end

    // Field capture from each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd <= '0;
        end else if (accept) begin
            case (expect_idx)
                2'd0: cmd.line_bytes <= wdata[LEN_W-1:0];
                2'd1: begin
                    cmd.is_write <= wdata[WORD_W-1];
                    cmd.base     <= wdata[ADDR_W-1:0];
                end
                2'd2: cmd.lines_m1 <= wdata[CNT_W-1:0];
                default: cmd.pitch <= wdata[STRIDE_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/line_walker.sv
// Issues one request per line, stepping the line address by the pitch.
// Assumes cmd is stable from launch until done.
module line_walker
    import sag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  xfer_cmd_t         cmd,
    input  logic              ready,
    output logic              valid,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              done,
    output logic              active
);
    logic [CNT_W-1:0] remain;
    logic             fire;

    // Handshake on the presented line.
    always_comb fire = active && ready;

    // Request presentation and final-line flag.
    always_comb begin
        valid = active;
        last  = active && (remain == '0);
    end

    // Line walk: load on launch, advance on each handshake, finish on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            done   <= 1'b0;
            addr   <= '0;
            remain <= '0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                addr   <= cmd.base;
                remain <= cmd.lines_m1;
                if (cmd.line_bytes == '0) done   <= 1'b1;
                else                      active <= 1'b1;
            end else if (fire) begin
                if (remain == '0) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    addr   <= addr + ADDR_W'(cmd.pitch);
                    remain <= remain - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/stride_addr_gen.sv
// Top of the 2D strided transfer address generator: command loader plus line walker.
// Assumes the consumer follows ready/valid rules; no buffering at the edge.
module stride_addr_gen
    import sag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              cmd_err,
    output logic              busy,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LEN_W-1:0]  req_len,
    output logic              req_write,
    output logic              req_last,
    output logic              done
);
    xfer_cmd_t             cfg;
    logic                  launch;
    logic                  walking;
    logic [STRIDE_W-1:0]   cfg_stride;

    // Busy covers the launch cycle and the whole walk.
    always_comb begin
        busy       = launch || walking;
        req_len    = cfg.line_bytes;
        req_write  = cfg.is_write;
        cfg_stride = cfg.pitch;
    end

    cmd_loader u_loader (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cmd_we),
        .idx    (cmd_idx),
        .wdata  (cmd_data),
        .busy   (busy),
        .cmd    (cfg),
        .launch (launch),
        .err    (cmd_err)
    );

    line_walker u_walker (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .cmd    (cfg),
        .ready  (req_ready),
        .valid  (req_valid),
        .addr   (req_addr),
        .last   (req_last),
        .done   (done),
        .active (walking)
    );
endmodule

// File: rtl/sag_checker.sv
// Protocol and sequencing properties for stride_addr_gen, attached by bind.
module sag_checker
    import sag_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_we,
    input logic                busy,
    input logic                cmd_err,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [LEN_W-1:0]    req_len,
    input logic                req_write,
    input logic                req_last,
    input logic                done,
    input logic [STRIDE_W-1:0] stride
);
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len)
                                    && $stable(req_write) && $stable(req_last));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_last |=>
            req_valid && (req_addr == $past(req_addr) + ADDR_W'($past(stride))));

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_last |=> done && !busy);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_write_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && busy |=> cmd_err);

    p_nonempty_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len != '0);

    p_last_only_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_last |-> req_valid);
endmodule

bind stride_addr_gen sag_checker u_sag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .busy      (busy),
    .cmd_err   (cmd_err),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_write (req_write),
    .req_last  (req_last),
    .done      (done),
    .stride    (cfg_stride)
);

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [1:0]  cmd_idx = '0;
    logic [31:0] cmd_data = '0;
    logic        cmd_err, busy, req_valid, req_write, req_last, done;
    logic        req_ready = 1'b0;
    logic [30:0] req_addr;
    logic [14:0] req_len;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    stride_addr_gen u_stride_addr_gen (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .cmd_err(cmd_err), .busy(busy),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .req_last(req_last), .done(done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [30:0] line_addr(input logic [30:0] base,
                                              input logic [23:0] pitch, input int n);
        logic [63:0] full;
        full = 64'(base) + 64'(pitch) * 64'(n);
        return full[30:0];
    endfunction

    task automatic put(input logic [1:0] i, input logic [31:0] d, input bit exp_err);
        @(negedge clk);
        cmd_we = 1'b1; cmd_idx = i; cmd_data = d;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(cmd_err == exp_err, exp_err ? "R6" : "R6", "cmd_err", 64'(cmd_err), 64'(exp_err));
    endtask

    task automatic send(input logic [14:0] xl, input bit dir, input logic [30:0] base,
                        input logic [23:0] yc, input logic [23:0] pitch);
        put(2'd0, {17'($urandom), xl}, 1'b0);
        put(2'd1, {dir, base}, 1'b0);
        put(2'd2, {8'($urandom), yc}, 1'b0);
        put(2'd3, {8'($urandom), pitch}, 1'b0);
    endtask

    task automatic collect(input logic [14:0] xl, input bit dir, input logic [30:0] base,
                           input logic [23:0] yc, input logic [23:0] pitch, input bit inject);
        int n = 0;
        int guard = 0;
        bit fin = 0;
        bit hold = 0;
        bit injected = 0;
        bit inj_now = 0;
        logic [30:0] s_addr;
        logic [14:0] s_len;
        logic s_wr, s_last;
        if (xl == 0) begin
            chk(!req_valid, "R10", "valid on launch", 64'(req_valid), 0);
            @(negedge clk);
            chk(done == 1'b1, "R10", "done", 64'(done), 1);
            chk(!req_valid, "R10", "valid", 64'(req_valid), 0);
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0, "R9", "idle after empty", 64'({done, busy}), 0);
            return;
        end
        while (!fin && guard < 5000) begin
            bit rdy;
            guard++;
            if (hold)
                chk(req_valid && req_addr == s_addr && req_len == s_len &&
                    req_write == s_wr && req_last == s_last, "R8", "hold",
                    64'(req_addr), 64'(s_addr));
            rdy = ($urandom % 4) != 0;
            req_ready = rdy;
            if (inject && req_valid && !injected) begin
                cmd_we = 1'b1; cmd_idx = 2'd0; cmd_data = 32'h0000_0001;
                injected = 1; inj_now = 1;
            end
            if (req_valid && rdy) begin
                chk(req_addr == line_addr(base, pitch, n), n == 0 ? "R3" : "R5", "addr",
                    64'(req_addr), 64'(line_addr(base, pitch, n)));
                chk(req_len == xl, "R1", "len", 64'(req_len), 64'(xl));
                chk(req_write == dir, "R2", "dir", 64'(req_write), 64'(dir));
                chk(req_last == (n == int'(yc)), "R4", "last", 64'(req_last), 64'(n == int'(yc)));
                if (req_last) fin = 1;
                n++;
            end
            hold = req_valid && !rdy;
            s_addr = req_addr; s_len = req_len; s_wr = req_write; s_last = req_last;
            @(negedge clk);
            cmd_we = 1'b0;
            if (inj_now) begin
                chk(cmd_err == 1'b1, "R7", "busy write err", 64'(cmd_err), 1);
                inj_now = 0;
            end
        end
        req_ready = 1'b0;
        chk(fin, "R4", "transfer finished", 64'(fin), 1);
        chk(n == int'(yc) + 1, "R4", "line count", 64'(n), 64'(int'(yc) + 1));
        chk(done == 1'b1 && busy == 1'b0, "R9", "done after last", 64'({done, busy}), 64'(2'b10));
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", 64'(done), 0);
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        chk({req_valid, req_last, done, busy, cmd_err} == 5'b0, "R11", "in reset",
            64'({req_valid, req_last, done, busy, cmd_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req_valid, req_last, done, busy, cmd_err} == 5'b0, "R11", "after reset",
            64'({req_valid, req_last, done, busy, cmd_err}), 0);

        // R4 twelve-line read with junk in unused bits (R1, R5)
        put(2'd0, 32'hFFFF_0040, 1'b0);
        put(2'd1, 32'h0000_1000, 1'b0);
        put(2'd2, 32'hAB00_000B, 1'b0);
        put(2'd3, 32'h1200_0780, 1'b0);
        collect(15'h40, 1'b0, 31'h1000, 24'd11, 24'h780, 1'b0);

        // R5 wrap of the 31-bit address, write direction
        send(15'd100, 1'b1, 31'h7FFF_FF00, 24'd3, 24'h100);
        collect(15'd100, 1'b1, 31'h7FFF_FF00, 24'd3, 24'h100, 1'b0);

        // R10 empty transfer, bit 15 set but ignored
        put(2'd0, 32'h0000_8000, 1'b0);
        put(2'd1, 32'h8000_2000, 1'b0);
        put(2'd2, 32'h0000_0004, 1'b0);
        put(2'd3, 32'h0000_0010, 1'b0);
        collect(15'd0, 1'b1, 31'h2000, 24'd4, 24'h10, 1'b0);

        // R6 out-of-order writes refused, sequence kept
        put(2'd2, 32'h0000_0009, 1'b1);
        put(2'd0, 32'h0000_0020, 1'b0);
        put(2'd3, 32'h0000_0999, 1'b1);
        put(2'd1, 32'h0000_0400, 1'b0);
        put(2'd1, 32'h0000_0777, 1'b1);
        put(2'd2, 32'h0000_0002, 1'b0);
        put(2'd3, 32'h0000_0040, 1'b0);
        collect(15'h20, 1'b0, 31'h400, 24'd2, 24'h40, 1'b0);

        // R7 write during a transfer is refused and leaves it intact
        send(15'd8, 1'b1, 31'h0000_0100, 24'd5, 24'h20);
        collect(15'd8, 1'b1, 31'h0000_0100, 24'd5, 24'h20, 1'b1);

        // random transfers
        for (int t = 0; t < 40; t++) begin
            logic [14:0] xl = (($urandom % 8) == 0) ? 15'd0 : 15'($urandom % 32767 + 1);
            bit          dir = 1'($urandom);
            logic [30:0] base = 31'($urandom);
            logic [23:0] yc = 24'($urandom % 8);
            logic [23:0] pitch = 24'($urandom);
            send(xl, dir, base, yc, pitch);
            collect(xl, dir, base, yc, pitch, (t % 5) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule